// File: doc/BRIEF.md
# Serial Password Protection Command Unit

This block is the command front end of a serial memory's 64-bit password protection feature. It acts as a mode-0 SPI slave: chip select, serial clock and serial data are brought into the system clock domain, and their edges are detected there. The first eight bits after chip select falls are taken as the instruction. The unit keeps a hidden 64-bit password, which can be written, compared or read out over the serial link. It also keeps a small status byte that reports a busy flag, a write-arm latch and an error flag.

Writing the password and checking an unlock attempt are both self-timed. They start when chip select rises and take a fixed number of system clocks, and the busy flag stays set for that time. A wrong unlock password leaves the error flag set and the busy flag stuck. Only the clear-status instruction or a hardware reset recovers from that state. Once the protection mode input selects password mode, password writes are refused. A successful unlock drives the locked output low.

Top module: `pwd_cmd_unit`

## Requirements
- R1: The instruction is the first 8 bits after chip select falls, sampled on SCK rising edges, MSB first. Instruction 05h returns the status byte on SO, MSB first, with bits changing on SCK falling edges. The status byte has busy in bit 0, write-arm in bit 1 and error in bit 6, and it repeats every 8 clocks.
- R2: Instruction 06h with no data bits sets the write-arm latch while the unit is idle.
- R3: Instruction E8h stores the 64 data bits as the new password when the write-arm latch is set and `pw_mode_n` is 1. The data arrives lowest byte first, MSB first within each byte. Busy then reads 1 for `OP_CYCLES` clocks, after which busy and write-arm both read 0.
- R4: An E8h command is ignored if the write-arm latch is clear.
- R5: An E8h or E9h frame whose data bit count at chip select rise is not exactly 64 is discarded. The password is unchanged and busy stays 0.
- R6: While `pw_mode_n` is 0, E8h commands are ignored and the stored password cannot change.
- R7: Instruction E7h returns the stored password on SO in the same byte and bit order as R3, with bits changing on SCK falling edges. The sequence repeats every 64 clocks while chip select stays low.
- R8: Instruction E9h with a password equal to the stored one sets busy for `OP_CYCLES` clocks. Busy then clears and `pwd_locked` goes to 0.
- R9: Instruction E9h with a mismatching password sets the error flag after `OP_CYCLES` clocks, and busy stays 1. `pwd_locked` stays 1.
- R10: Instruction 30h clears the error flag, busy and write-arm, even while busy is stuck.
- R11: While busy is 1, every instruction other than 05h and 30h is ignored. In that state E7h returns zeros.
- R12: After reset the password is all ones, the status byte is 00h, `pwd_locked` is 1 and SO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock (mode 0) |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| pw_mode_n | input | 1 | Protection mode bit; 0 selects password mode |
| pwd_locked | output | 1 | 1 until a successful unlock |

## Verification
The following are checked on every cycle by the assertions:
- A stuck failure state holds until a clear-status instruction.
- The error flag is never set without busy.
- A password write starts only with the write-arm latch set and password mode not selected.
- The write-arm latch is clear once a write ends.
- The password is frozen while password mode is selected.
- `pwd_locked` falls only at the end of an unlock.
- SO is quiet while chip select is high.

Only the bench's scenarios can show the following:
- The byte and bit ordering of the password on the wire.
- That frames with the wrong length are rejected across a sweep of bit counts.
- The status values seen during and after each operation.
- That reads repeat every 64 clocks.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int PW_BITS = 64;
  localparam int IDX_W   = $clog2(PW_BITS);

  localparam logic [7:0] OPC_ARM    = 8'h06;
  localparam logic [7:0] OPC_STATUS = 8'h05;
  localparam logic [7:0] OPC_CLEAR  = 8'h30;
  localparam logic [7:0] OPC_PWWR   = 8'hE8;
  localparam logic [7:0] OPC_PWCHK  = 8'hE9;
  localparam logic [7:0] OPC_PWRD   = 8'hE7;

  typedef enum logic [1:0] {
    EX_IDLE,
    EX_WRITE,
    EX_CHECK,
    EX_STUCK
  } ex_state_e;
endpackage

// File: rtl/pwd_sync.sv
module pwd_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwd_shifter.sv
module pwd_shifter
  import pwd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_s,
  input  logic               cs_s,
  input  logic               si_s,
  input  logic               busy,
  input  logic [7:0]         status,
  input  logic [PW_BITS-1:0] pw,
  output logic [7:0]         opcode,
  output logic               op_valid,
  output logic               frame_ok,
  output logic               bare,
  output logic [PW_BITS-1:0] data,
  output logic               cs_rise,
  output logic               so
);
  logic             sck_d, cs_d;
  logic             sck_rise, sck_fall;
  logic [3:0]       bitcnt_q, bitcnt_n;
  logic [7:0]       opc_q, opc_n;
  logic [IDX_W-1:0] dcnt_q, dcnt_n;
  logic [IDX_W-1:0] didx;
  logic             full_q, full_n, ovf_q, ovf_n;
  logic             so_q, so_n;
  logic [PW_BITS-1:0] data_q;
  logic             data_we, so_we;

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_rise  = cs_s & ~cs_d;
  assign op_valid = (bitcnt_q == 4'd8);
  assign didx     = {dcnt_q[IDX_W-1:3], ~dcnt_q[2:0]};
  assign data_we  = ~cs_s & sck_rise & op_valid;
  assign so_we    = cs_s | (sck_fall & op_valid);

  always_comb begin
    bitcnt_n = bitcnt_q;
    opc_n    = opc_q;
    dcnt_n   = dcnt_q;
    full_n   = full_q;
    ovf_n    = ovf_q;
    so_n     = so_q;
    if (cs_s) begin
      bitcnt_n = '0;
      dcnt_n   = '0;
      full_n   = 1'b0;
      ovf_n    = 1'b0;
      so_n     = 1'b0;
    end else begin
      if (sck_rise) begin
        if (!op_valid) begin
          opc_n    = {opc_q[6:0], si_s};
          bitcnt_n = bitcnt_q + 4'd1;
        end else begin
          dcnt_n = dcnt_q + 1'b1;
          if (full_q) ovf_n = 1'b1;
          if (&dcnt_q) full_n = 1'b1;
        end
      end
      if (sck_fall && op_valid) begin
        case (opc_q)
          OPC_PWRD:   so_n = busy ? 1'b0 : pw[didx];
          OPC_STATUS: so_n = status[~dcnt_q[2:0]];
          default:    so_n = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      cs_d     <= 1'b1;
      bitcnt_q <= '0;
      opc_q    <= '0;
      dcnt_q   <= '0;
      full_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      cs_d     <= cs_s;
      bitcnt_q <= bitcnt_n;
      opc_q    <= opc_n;
      dcnt_q   <= dcnt_n;
      full_q   <= full_n;
      ovf_q    <= ovf_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) so_q <= 1'b0;
    else if (so_we) so_q <= so_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (data_we) data_q[didx] <= si_s;
  end

  assign opcode   = opc_q;
  assign data     = data_q;
  assign frame_ok = full_q & ~ovf_q;
  assign bare     = op_valid & ~full_q & (dcnt_q == '0);
  assign so       = so_q;

  p_so_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !so_q);
  p_opcode_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_q <= 4'd8);
  p_overrun_after_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> full_q);
endmodule

// File: rtl/pwd_exec.sv
module pwd_exec
  import pwd_pkg::*;
#(
  parameter int OP_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_rise,
  input  logic [7:0]         opcode,
  input  logic               op_valid,
  input  logic               frame_ok,
  input  logic               bare,
  input  logic [PW_BITS-1:0] data,
  input  logic               pw_mode_n,
  output logic               busy,
  output logic [7:0]         status,
  output logic [PW_BITS-1:0] pw,
  output logic               locked
);
  localparam int TW = $clog2(OP_CYCLES + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(OP_CYCLES - 1);

  ex_state_e        st_q, st_n;
  logic [TW-1:0]    tmr_q, tmr_n;
  logic             arm_q, arm_n, err_q, err_n;
  logic             match_q, match_n, lock_q, lock_n;
  logic [PW_BITS-1:0] pw_q, pw_n;
  logic             cmd, clear_hit, pw_we;

  assign cmd       = cs_rise & op_valid;
  assign clear_hit = cmd & bare & (opcode == OPC_CLEAR);

  always_comb begin
    st_n    = st_q;
    tmr_n   = tmr_q;
    arm_n   = arm_q;
    err_n   = err_q;
    match_n = match_q;
    lock_n  = lock_q;
    pw_n    = pw_q;
    pw_we   = 1'b0;
    if (clear_hit) begin
      st_n  = EX_IDLE;
      tmr_n = '0;
      arm_n = 1'b0;
      err_n = 1'b0;
    end else if (cmd && st_q == EX_IDLE) begin
      if (opcode == OPC_ARM && bare) begin
        arm_n = 1'b1;
      end else if (opcode == OPC_PWWR && frame_ok && arm_q && pw_mode_n) begin
        pw_n  = data;
        pw_we = 1'b1;
        st_n  = EX_WRITE;
        tmr_n = T_LOAD;
      end else if (opcode == OPC_PWCHK && frame_ok) begin
        match_n = (data == pw_q);
        st_n    = EX_CHECK;
        tmr_n   = T_LOAD;
      end
    end else if (st_q == EX_WRITE || st_q == EX_CHECK) begin
      if (tmr_q == '0) begin
        if (st_q == EX_WRITE) begin
          st_n  = EX_IDLE;
          arm_n = 1'b0;
        end else if (match_q) begin
          st_n   = EX_IDLE;
          lock_n = 1'b0;
        end else begin
          st_n  = EX_STUCK;
          err_n = 1'b1;
        end
      end else begin
        tmr_n = tmr_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= EX_IDLE;
      tmr_q   <= '0;
      arm_q   <= 1'b0;
      err_q   <= 1'b0;
      match_q <= 1'b0;
      lock_q  <= 1'b1;
    end else begin
      st_q    <= st_n;
      tmr_q   <= tmr_n;
      arm_q   <= arm_n;
      err_q   <= err_n;
      match_q <= match_n;
      lock_q  <= lock_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pw_q <= '1;
    else if (pw_we) pw_q <= pw_n;
  end

  assign busy   = (st_q != EX_IDLE);
  assign status = {1'b0, err_q, 4'b0000, arm_q, busy};
  assign pw     = pw_q;
  assign locked = lock_q;

  p_stuck_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == EX_STUCK && !clear_hit) |=> (st_q == EX_STUCK));
  p_err_with_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (st_q == EX_STUCK));
  p_write_needs_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == EX_WRITE) |-> ($past(arm_q) && $past(pw_mode_n)));
  p_arm_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_q == EX_WRITE) |-> !arm_q);
  p_pw_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pw_mode_n && $past(!pw_mode_n)) |-> $stable(pw_q));
  p_unlock_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(st_q == EX_CHECK));
endmodule

// File: rtl/pwd_cmd_unit.sv
module pwd_cmd_unit
  import pwd_pkg::*;
#(
  parameter int OP_CYCLES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_si,
  output logic spi_so,
  input  logic pw_mode_n,
  output logic pwd_locked
);
  logic [2:0]         pins_s;
  logic               sck_s, cs_s, si_s;
  logic [7:0]         opcode, status;
  logic               op_valid, frame_ok, bare, cs_rise, busy;
  logic [PW_BITS-1:0] data, pw;

  pwd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sck, spi_cs_n, spi_si}),
    .q     (pins_s)
  );
  assign sck_s = pins_s[2];
  assign cs_s  = pins_s[1];
  assign si_s  = pins_s[0];

  pwd_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (sck_s),
    .cs_s     (cs_s),
    .si_s     (si_s),
    .busy     (busy),
    .status   (status),
    .pw       (pw),
    .opcode   (opcode),
    .op_valid (op_valid),
    .frame_ok (frame_ok),
    .bare     (bare),
    .data     (data),
    .cs_rise  (cs_rise),
    .so       (spi_so)
  );

  pwd_exec #(.OP_CYCLES(OP_CYCLES)) u_exec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_rise   (cs_rise),
    .opcode    (opcode),
    .op_valid  (op_valid),
    .frame_ok  (frame_ok),
    .bare      (bare),
    .data      (data),
    .pw_mode_n (pw_mode_n),
    .busy      (busy),
    .status    (status),
    .pw        (pw),
    .locked    (pwd_locked)
  );
endmodule

// File: tb/pwd_cmd_unit_test.sv
`timescale 1ns/1ps
module pwd_cmd_unit_test;
  localparam int OPC  = 4000;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0, pw_mode_n = 1'b1;
  logic spi_so, pwd_locked;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pwd_cmd_unit #(.OP_CYCLES(OPC)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .spi_so(spi_so), .pw_mode_n(pw_mode_n),
    .pwd_locked(pwd_locked)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic b, output logic r);
    @(posedge clk); #1 spi_si = b;
    repeat (HALF) @(posedge clk);
    #1 r = spi_so; spi_sck = 1'b1;
    repeat (HALF) @(posedge clk);
    #1 spi_sck = 1'b0;
  endtask

  task automatic cs_lo();
    @(posedge clk); #1 spi_cs_n = 1'b0;
    repeat (HALF) @(posedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(posedge clk);
    #1 spi_cs_n = 1'b1;
    repeat (12) @(posedge clk);
  endtask

  task automatic send_op(input logic [7:0] op);
    logic r;
    for (int i = 7; i >= 0; i--) xfer(op[i], r);
  endtask

  task automatic simple(input logic [7:0] op);
    cs_lo(); send_op(op); cs_hi();
  endtask

  // lowest byte first, MSB first within each byte
  function automatic int wire_idx(input int k);
    return 8 * ((k % 64) / 8) + 7 - (k % 8);
  endfunction

  task automatic pw_cmd(input logic [7:0] op, input logic [63:0] p, input int nbits);
    logic r;
    cs_lo(); send_op(op);
    for (int k = 0; k < nbits; k++) xfer(p[wire_idx(k)], r);
    cs_hi();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic r;
    cs_lo(); send_op(8'h05);
    for (int i = 7; i >= 0; i--) begin xfer(1'b0, r); s[i] = r; end
    cs_hi();
  endtask

  task automatic rd_pw(input int nbits, output logic [63:0] a, output logic [63:0] b);
    logic r;
    a = '0; b = '0;
    cs_lo(); send_op(8'hE7);
    for (int k = 0; k < nbits; k++) begin
      xfer(1'b0, r);
      if (k < 64) a[wire_idx(k)] = r; else b[wire_idx(k)] = r;
    end
    cs_hi();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  st;
    logic [63:0] a, b;
    logic [63:0] p1, p2, p3, p4;
    p1 = 64'h0123_4567_89AB_CDEF;
    p2 = 64'hA5A5_0F0F_3C3C_8001;
    p3 = 64'hFEDC_BA98_7654_3210;
    p4 = 64'h1111_2222_3333_4444;

    repeat (5) @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(posedge clk); #1;
    // R12 reset state
    check("R12 so", {63'b0, spi_so}, 64'd0);
    check("R12 locked", {63'b0, pwd_locked}, 64'd1);
    rd_status(st); check("R12 status", {56'b0, st}, 64'h00);
    rd_pw(64, a, b); check("R12 password", a, '1);

    // R2 arm latch
    simple(8'h06);
    rd_status(st); check("R2 arm set", {56'b0, st}, 64'h02);

    // R3 program, R1 status while busy
    pw_cmd(8'hE8, p1, 64);
    rd_status(st); check("R3/R1 status busy", {56'b0, st}, 64'h03);
    repeat (OPC + 200) @(posedge clk);
    rd_status(st); check("R3 done status", {56'b0, st}, 64'h00);
    // R7 read twice around
    rd_pw(128, a, b);
    check("R7 read first pass", a, p1);
    check("R7 read repeat", b, p1);

    // R4 no arm
    pw_cmd(8'hE8, p2, 64);
    rd_status(st); check("R4 status", {56'b0, st}, 64'h00);
    rd_pw(64, a, b); check("R4 password kept", a, p1);

    // R5 length sweep
    simple(8'h06);
    for (int n = 56; n <= 72; n += 2) begin
      if (n != 64) begin
        pw_cmd(8'hE8, p2, n);
        rd_status(st); check($sformatf("R5 len %0d status", n), {56'b0, st}, 64'h02);
      end
    end
    pw_cmd(8'hE8, p2, 1);
    rd_status(st); check("R5 len 1 status", {56'b0, st}, 64'h02);
    rd_pw(64, a, b); check("R5 password kept", a, p1);
    pw_cmd(8'hE9, p2, 63);
    rd_status(st); check("R5 unlock short", {56'b0, st}, 64'h02);

    // program p3, R11 ignore during busy
    pw_cmd(8'hE8, p3, 64);
    rd_pw(64, a, b); check("R11 read while busy", a, 64'd0);
    pw_cmd(8'hE9, p3, 64);
    repeat (OPC + 200) @(posedge clk);
    rd_status(st); check("R11 unlock ignored", {56'b0, st}, 64'h00);
    check("R11 locked still", {63'b0, pwd_locked}, 64'd1);
    rd_pw(64, a, b); check("R3 second program", a, p3);

    // R9 mismatch
    pw_cmd(8'hE9, p4, 64);
    repeat (OPC + 200) @(posedge clk);
    rd_status(st); check("R9 stuck status", {56'b0, st}, 64'h41);
    check("R9 locked", {63'b0, pwd_locked}, 64'd1);
    simple(8'h06);
    rd_status(st); check("R11 arm ignored when stuck", {56'b0, st}, 64'h41);

    // R10 clear
    simple(8'h30);
    rd_status(st); check("R10 clear stuck", {56'b0, st}, 64'h00);
    simple(8'h06);
    simple(8'h30);
    rd_status(st); check("R10 clear arm", {56'b0, st}, 64'h00);

    // R6 password mode
    #1 pw_mode_n = 1'b0;
    simple(8'h06);
    pw_cmd(8'hE8, p4, 64);
    rd_status(st); check("R6 write refused", {56'b0, st}, 64'h02);
    rd_pw(64, a, b); check("R6 password kept", a, p3);

    // R8 good unlock
    pw_cmd(8'hE9, p3, 64);
    rd_status(st); check("R8 busy", {56'b0, st}, 64'h03);
    repeat (OPC + 200) @(posedge clk);
    rd_status(st); check("R8 done", {56'b0, st}, 64'h02);
    check("R8 unlocked", {63'b0, pwd_locked}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule